// File: doc/BRIEF.md
# Running Rank-Order Filter

This block filters a stream of samples by rank. It holds the most recent window of samples as an array of processing elements that is always sorted in ascending order. When a sample arrives, the block removes the oldest sample from the array and places the new one at its sorted position. This delete-and-insert step happens in place, in one clock cycle, and the array is never rebuilt.

Each element holds a value and an age tag. Each element also compares its own value with the arriving sample. From these local results every element decides whether to keep its value, take the value of a neighbour, or load the new sample. The value at a selectable rank is then read from the array. By default that rank is the median, so the block works as a running median filter on one-dimensional data. Assembling 2-D windows and handling borders are left to the surrounding logic.

Top module: `running_median_filter`

## Requirements
- R1: When output valid is high, `out_data_o` equals the r-th smallest of the last `WIN` accepted samples. Rank r = 0 is the smallest sample and rank r = `WIN`-1 is the largest. r is the rank given with the beat that produced the output.
- R2: `out_valid_o` is high in the cycle after an accepted beat (`in_valid_i` high) if the window is then full. It is low in every other cycle.
- R3: `out_valid_o` stays low until `WIN` samples have been accepted since reset. During filling, no sample is removed.
- R4: The sample removed on each update is the oldest one in the window. This holds even when the window contains several entries equal to the oldest value.
- R5: A rank of `WIN` or more on `rank_i` is treated as rank `WIN`/2, the median (the upper median for an even window).
- R6: `rank_i` and `in_data_i` have no effect while `in_valid_i` is low. The window contents are kept unchanged until the next accepted beat.
- R7: After reset, `out_valid_o` is 0 and `out_data_o` is 0, and the window is empty.
- R8: The element array stays sorted in ascending order, and its occupied entries form a contiguous prefix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample is valid this cycle |
| in_data_i | input | DW | Input sample, unsigned |
| rank_i | input | $clog2(WIN)+1 | Requested output rank, 0 is the smallest |
| out_valid_o | output | 1 | Output sample valid |
| out_data_o | output | DW | Sample at the requested rank |

## Verification
The hardest case to reach from the ports is deleting the oldest sample when equal values exist at several positions. In that case, the element to remove can only be found by its age, not by its value. The stimulus builds this case with long runs of samples drawn from only four values. Other runs separate beats with idle gaps and change the rank while the input is idle. A behavioural queue model checks every cycle, including the cycles just after a mid-stream reset, when the window refills.

// File: rtl/rmf_pkg.sv
package rmf_pkg;
  // Out-of-range rank requests fall back to the median position.
  function automatic int unsigned fix_rank(int unsigned r, int unsigned n);
    return (r < n) ? r : n / 2;
  endfunction
endpackage

// File: rtl/rmf_pe.sv
module rmf_pe #(
  parameter int DW = 8,
  parameter int AW = 6,
  parameter int LAST_AGE = 63
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  logic          full_i,
  input  logic [DW-1:0] x_i,
  input  logic          past_i,
  input  logic [DW-1:0] lo_val_i,
  input  logic [AW-1:0] lo_age_i,
  input  logic          lo_up_i,
  input  logic          lo_occ_i,
  input  logic [DW-1:0] hi_val_i,
  input  logic [AW-1:0] hi_age_i,
  input  logic          hi_dn_i,
  output logic [DW-1:0] val_o,
  output logic [AW-1:0] age_o,
  output logic          occ_o,
  output logic          del_o,
  output logic          up_o,
  output logic          dn_o
);
  logic [DW-1:0] val_q;
  logic [AW-1:0] age_q;
  logic          occ_q;
  logic          live, below, hold;

  // compare cell
  assign del_o = full_i && occ_q && (age_q == AW'(LAST_AGE));
  assign live  = occ_q && !del_o;
  assign below = live && (val_q <= x_i);   // equal entries stay ahead of new sample
  assign up_o  = live && !below && !past_i;
  assign dn_o  = below && past_i;
  assign hold  = live && (below != past_i);

  // sort cell
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      age_q <= '0;
      occ_q <= 1'b0;
    end else if (upd_i) begin
      occ_q <= occ_q | lo_occ_i;
      if (hi_dn_i) begin
        val_q <= hi_val_i;
        age_q <= hi_age_i + 1'b1;
      end else if (lo_up_i) begin
        val_q <= lo_val_i;
        age_q <= lo_age_i + 1'b1;
      end else if (hold) begin
        age_q <= age_q + 1'b1;
      end else if (occ_q || lo_occ_i) begin
        val_q <= x_i;
        age_q <= '0;
      end
    end
  end

  assign val_o = val_q;
  assign age_o = age_q;
  assign occ_o = occ_q;
endmodule

// File: rtl/rmf_rank_sel.sv
module rmf_rank_sel #(
  parameter int DW = 8,
  parameter int WIN = 64,
  localparam int AW = $clog2(WIN)
) (
  input  logic [WIN*DW-1:0] vals_i,
  input  logic [AW-1:0]     rank_i,
  output logic [DW-1:0]     data_o
);
  assign data_o = vals_i[rank_i*DW +: DW];
endmodule

// File: rtl/running_median_filter.sv
module running_median_filter
  import rmf_pkg::*;
#(
  parameter int DW = 8,
  parameter int WIN = 64,
  localparam int AW = $clog2(WIN),
  localparam int RW = AW + 1,
  localparam int CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic [DW-1:0] in_data_i,
  input  logic [RW-1:0] rank_i,
  output logic          out_valid_o,
  output logic [DW-1:0] out_data_o
);
  logic [CW-1:0] cnt_q;
  logic          full;
  logic [AW-1:0] rank_q;
  logic          out_valid_q;

  logic [DW-1:0] val  [WIN];
  logic [AW-1:0] age  [WIN];
  logic          occ  [WIN];
  logic          del  [WIN];
  logic          up   [WIN];
  logic          dn   [WIN];
  logic          past [WIN];
  logic [WIN*DW-1:0] vals_flat;
  logic [WIN-1:0]    occ_vec;

  assign full = (cnt_q == CW'(WIN));

  for (genvar g = 0; g < WIN; g++) begin : g_pe
    logic [DW-1:0] lo_val, hi_val;
    logic [AW-1:0] lo_age, hi_age;
    logic          lo_up, lo_occ, hi_dn;

    if (g == 0) begin : g_first
      assign past[g] = 1'b0;
      assign lo_val  = '0;
      assign lo_age  = '0;
      assign lo_up   = 1'b0;
      assign lo_occ  = 1'b1;
    end else begin : g_mid
      assign past[g] = past[g-1] | del[g-1];
      assign lo_val  = val[g-1];
      assign lo_age  = age[g-1];
      assign lo_up   = up[g-1];
      assign lo_occ  = occ[g-1];
    end

    if (g == WIN - 1) begin : g_last
      assign hi_val = '0;
      assign hi_age = '0;
      assign hi_dn  = 1'b0;
    end else begin : g_notlast
      assign hi_val = val[g+1];
      assign hi_age = age[g+1];
      assign hi_dn  = dn[g+1];
    end

    rmf_pe #(.DW(DW), .AW(AW), .LAST_AGE(WIN - 1)) u_pe (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .upd_i    (in_valid_i),
      .full_i   (full),
      .x_i      (in_data_i),
      .past_i   (past[g]),
      .lo_val_i (lo_val),
      .lo_age_i (lo_age),
      .lo_up_i  (lo_up),
      .lo_occ_i (lo_occ),
      .hi_val_i (hi_val),
      .hi_age_i (hi_age),
      .hi_dn_i  (hi_dn),
      .val_o    (val[g]),
      .age_o    (age[g]),
      .occ_o    (occ[g]),
      .del_o    (del[g]),
      .up_o     (up[g]),
      .dn_o     (dn[g])
    );

    assign vals_flat[g*DW +: DW] = val[g];
    assign occ_vec[g]            = occ[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      rank_q      <= '0;
      out_valid_q <= 1'b0;
    end else begin
      out_valid_q <= in_valid_i && (cnt_q >= CW'(WIN - 1));
      if (in_valid_i) begin
        rank_q <= AW'(fix_rank(32'(rank_i), WIN));
        if (!full) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  rmf_rank_sel #(.DW(DW), .WIN(WIN)) u_sel (
    .vals_i (vals_flat),
    .rank_i (rank_q),
    .data_o (out_data_o)
  );

  assign out_valid_o = out_valid_q;
endmodule

// File: rtl/rmf_chk.sv
module rmf_chk #(
  parameter int DW = 8,
  parameter int WIN = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              out_valid_o,
  input logic [WIN*DW-1:0] vals_i,
  input logic [WIN-1:0]    occ_i
);
  int unsigned seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 0;
    else if (in_valid_i && seen_q < WIN) seen_q <= seen_q + 1;
  end

  p_fill_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q < WIN) |-> !out_valid_o);
  p_occ_count_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(occ_i) == seen_q);
  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(in_valid_i));
  p_full_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && seen_q == WIN) |=> out_valid_o);
  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(vals_i) && $stable(occ_i)));

  for (genvar g = 0; g < WIN - 1; g++) begin : g_ord
    p_sorted_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      occ_i[g+1] |-> (vals_i[g*DW +: DW] <= vals_i[(g+1)*DW +: DW]));
    p_prefix_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      occ_i[g+1] |-> occ_i[g]);
  end
endmodule

bind running_median_filter rmf_chk #(.DW(DW), .WIN(WIN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .out_valid_o (out_valid_o),
  .vals_i      (vals_flat),
  .occ_i       (occ_vec)
);

// File: tb/sim_running_median_filter.sv
`timescale 1ns/1ps
module sim_running_median_filter;
  localparam int DW  = 8;
  localparam int WIN = 64;
  localparam int RW  = $clog2(WIN) + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [RW-1:0] rank = '0;
  logic          out_valid;
  logic [DW-1:0] out_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  int q[$];
  bit exp_v   = 1'b0;
  int exp_d   = 0;
  string tag  = "R1";

  always #2.5 clk = ~clk;

  running_median_filter #(.DW(DW), .WIN(WIN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .rank_i(rank), .out_valid_o(out_valid), .out_data_o(out_data)
  );

  task automatic check(string req, int act, int expv);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  // One cycle: check the result of the previous edge, then drive the next beat.
  task automatic step(bit v, int d, int r);
    @(negedge clk);
    check((exp_v || out_valid) ? "R2/R3 valid" : "R2 idle", int'(out_valid), int'(exp_v));
    if (exp_v) check(tag, int'(out_data), exp_d);
    in_valid = v;
    in_data  = DW'(d);
    rank     = RW'(r);
    exp_v    = 1'b0;
    if (v) begin
      q.push_back(d);
      if (q.size() > WIN) void'(q.pop_front());
      if (q.size() == WIN) begin
        int s[$];
        int rr;
        s = q;
        s.sort();
        rr = (r < WIN) ? r : WIN / 2;
        exp_v = 1'b1;
        exp_d = s[rr];
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    q.delete();
    exp_v = 1'b0;
    @(negedge clk);
    check("R7 out_valid", int'(out_valid), 0);
    check("R7 out_data", int'(out_data), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R3: fill, valid must stay low until the window is full
    tag = "R3";
    for (int i = 0; i < WIN; i++) step(1'b1, (i * 37) % 256, WIN / 2);
    // R1: random data, random legal rank
    tag = "R1";
    for (int i = 0; i < 300; i++) step(1'b1, $urandom_range(0, 255), $urandom_range(0, WIN - 1));
    // R6: idle gaps with garbage rank and data
    tag = "R6";
    for (int i = 0; i < 150; i++) begin
      step(1'b1, $urandom_range(0, 255), $urandom_range(0, WIN - 1));
      if (i % 3 == 0) begin
        step(1'b0, $urandom_range(0, 255), $urandom_range(0, 2 * WIN - 1));
        step(1'b0, 255, WIN + 1);
      end
    end
    // R4: heavy duplicates, oldest must leave
    tag = "R4";
    for (int i = 0; i < 300; i++) step(1'b1, $urandom_range(0, 3), $urandom_range(0, WIN - 1));
    for (int i = 0; i < 80; i++) step(1'b1, (i < 40) ? 2 : 1, (i % 2) ? 0 : WIN - 1);
    // R5: out-of-range ranks clamp to the median
    tag = "R5";
    for (int i = 0; i < 100; i++) step(1'b1, $urandom_range(0, 255), $urandom_range(WIN, 2 * WIN - 1));
    // R1: extremes at the lowest and highest rank
    tag = "R1";
    for (int i = 0; i < 100; i++) step(1'b1, (i % 2) ? 255 : 0, (i % 4 < 2) ? 0 : WIN - 1);
    // R7: reset mid-stream, then refill
    do_reset();
    tag = "R3";
    for (int i = 0; i < WIN + 40; i++) step(1'b1, $urandom_range(0, 255), $urandom_range(0, 2 * WIN - 1));
    step(1'b0, 0, 0);
    step(1'b0, 0, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule